// File: doc/BRIEF.md
# Latched Parity Bus Transceiver

This block moves data in either direction between an A bus and a B bus. The data is split into byte lanes that all share one set of controls, and each lane carries a data byte plus one parity bit. Each bus has its own input latch. A latch is transparent while its enable is high. While the enable is low, the latch keeps the value it captured at the last clock edge on which the enable was high. The pads are modelled as separate input, output-value and drive-enable signals, so the block stays synthesizable.

Two active-low output enables choose the direction: A to B, B to A, or idle, where neither bus is driven. The parity bit sent on the outgoing bus is either computed from the byte or copied from the incoming parity bit, as the mode input selects. A second input selects odd or even parity. Each bus, in each lane, has its own active-low parity-error output. The check on the receiving bus only counts while both latches are transparent, so one pass through the block can catch faults on the source side and on the destination side. Pulling both output enables low is illegal: the block then drives neither bus and sets a sticky flag.

Top module: `parity_xcvr`

## Requirements
- R1: The direction decode is as follows. `oe_b_n`=0 with `oe_a_n`=1 drives the B bus from the A side (`b_drv`=1, `a_drv`=0). `oe_a_n`=0 with `oe_b_n`=1 drives the A bus from the B side. Both high drives neither bus.
- R2: When both output enables are low, neither bus is driven. On the following clock edge `cfg_err` goes to 1, and it stays at 1 until a synchronous reset (`rst_n`=0) clears it.
- R3: While the source-side latch enable is high, the driven data byte follows that bus's input in the same cycle.
- R4: While the source-side latch enable is low, the driven data is the value that was on that bus at the last clock edge on which its enable was high.
- R5: With `par_thru`=0, the driven parity bit is computed from the driven byte (live or latched). With `odd_sel`=0 it is the XOR of the 8 bits; with `odd_sel`=1 it is the inverse of that XOR.
- R6: With `par_thru`=1, the driven parity bit equals the source latch's parity bit.
- R7: The source bus's error output is 0 whenever its latched byte and parity bit hold an odd count of ones while `odd_sel`=0, or an even count while `odd_sel`=1. Otherwise it is 1.
- R8: The receiving bus is checked by the same rule only while both latch enables are high. At any other time its error output is 1.
- R9: In idle, and in the illegal state, both buses are checked by the R7 rule at all times.
- R10: Lanes are independent: lane k uses data bits [8k+7:8k] and parity bit k, and an error in one lane affects no other lane's outputs.
- R11: Reset clears both held latch values to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the latch hold registers |
| rst_n | input | 1 | Synchronous active-low reset |
| oe_a_n | input | 1 | Active-low enable to drive the A bus |
| oe_b_n | input | 1 | Active-low enable to drive the B bus |
| le_a | input | 1 | A-side latch enable, transparent when high |
| le_b | input | 1 | B-side latch enable, transparent when high |
| par_thru | input | 1 | 1 passes the parity bit through, 0 computes it |
| odd_sel | input | 1 | 1 selects odd parity, 0 selects even parity |
| a_dat_in | input | LANES*DW | A bus data seen at the pads |
| a_par_in | input | LANES | A bus parity bits seen at the pads |
| b_dat_in | input | LANES*DW | B bus data seen at the pads |
| b_par_in | input | LANES | B bus parity bits seen at the pads |
| a_dat_out | output | LANES*DW | Data value to drive onto the A bus |
| a_par_out | output | LANES | Parity value to drive onto the A bus |
| a_drv | output | 1 | A bus drive enable |
| b_dat_out | output | LANES*DW | Data value to drive onto the B bus |
| b_par_out | output | LANES | Parity value to drive onto the B bus |
| b_drv | output | 1 | B bus drive enable |
| err_a_n | output | LANES | Active-low parity error on the A bus, one per lane |
| err_b_n | output | LANES | Active-low parity error on the B bus, one per lane |
| cfg_err | output | 1 | Sticky flag for the illegal output-enable state |

## Verification
The assertions check on every cycle that the two buses are never driven together, that each enable pair decodes to the right drive, and that the illegal state sets the flag and the flag stays set. They also check that a closed source latch keeps the driven data steady, that feed-through copies the parity bit, and that the receiving bus reports no error while either latch is closed. The bench's scenarios are what show correct computed parity under both odd and even selection, the values captured at particular edges, and error detection when single-bit faults are injected on the source bus and on the looped-back receiving bus, for every legal combination of controls. Only the bench shows lane independence and the reset clearing the held values.

// File: rtl/pxc_pkg.sv
package pxc_pkg;

  typedef enum logic [1:0] {
    XDIR_IDLE = 2'd0,
    XDIR_A2B  = 2'd1,
    XDIR_B2A  = 2'd2,
    XDIR_BAD  = 2'd3
  } xdir_e;

  // parity bit that makes byte+bit satisfy the selected rule
  function automatic logic gen_par(input logic [7:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction

endpackage

// File: rtl/pxc_latch.sv
module pxc_latch #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         le,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (!rst_n)  hold_q <= '0;
    else if (le) hold_q <= d;
  end

  assign q = le ? d : hold_q;
endmodule

// File: rtl/pxc_ctrl.sv
module pxc_ctrl
  import pxc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  oe_a_n,
  input  logic  oe_b_n,
  output xdir_e dir,
  output logic  cfg_err
);
  logic bad_q;

  always_comb begin
    unique case ({oe_a_n, oe_b_n})
      2'b11:   dir = XDIR_IDLE;
      2'b10:   dir = XDIR_A2B;
      2'b01:   dir = XDIR_B2A;
      default: dir = XDIR_BAD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)               bad_q <= 1'b0;
    else if (dir == XDIR_BAD) bad_q <= 1'b1;
  end

  assign cfg_err = bad_q;
endmodule

// File: rtl/pxc_lane.sv
module pxc_lane
  import pxc_pkg::*;
#(
  parameter int DW = 8
) (
  input  xdir_e         dir,
  input  logic          par_thru,
  input  logic          odd_sel,
  input  logic          le_a,
  input  logic          le_b,
  input  logic [DW-1:0] a_dat,
  input  logic          a_par,
  input  logic [DW-1:0] b_dat,
  input  logic          b_par,
  output logic [DW-1:0] a_out_dat,
  output logic          a_out_par,
  output logic [DW-1:0] b_out_dat,
  output logic          b_out_par,
  output logic          err_a_n,
  output logic          err_b_n
);
  logic both_open, a_bad, b_bad, a_on, b_on;

  assign both_open = le_a & le_b;

  // the latched value of each bus feeds the opposite bus
  assign b_out_dat = a_dat;
  assign a_out_dat = b_dat;
  assign b_out_par = par_thru ? a_par : ((^a_dat) ^ odd_sel);
  assign a_out_par = par_thru ? b_par : ((^b_dat) ^ odd_sel);

  assign a_bad = ((^a_dat) ^ a_par) != odd_sel;
  assign b_bad = ((^b_dat) ^ b_par) != odd_sel;

  // the receiving side is only checked while both latches are open
  assign a_on = (dir != XDIR_B2A) | both_open;
  assign b_on = (dir != XDIR_A2B) | both_open;

  assign err_a_n = ~(a_bad & a_on);
  assign err_b_n = ~(b_bad & b_on);
endmodule

// File: rtl/parity_xcvr.sv
module parity_xcvr
  import pxc_pkg::*;
#(
  parameter int LANES = 2,
  parameter int DW    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                oe_a_n,
  input  logic                oe_b_n,
  input  logic                le_a,
  input  logic                le_b,
  input  logic                par_thru,
  input  logic                odd_sel,
  input  logic [LANES*DW-1:0] a_dat_in,
  input  logic [LANES-1:0]    a_par_in,
  input  logic [LANES*DW-1:0] b_dat_in,
  input  logic [LANES-1:0]    b_par_in,
  output logic [LANES*DW-1:0] a_dat_out,
  output logic [LANES-1:0]    a_par_out,
  output logic                a_drv,
  output logic [LANES*DW-1:0] b_dat_out,
  output logic [LANES-1:0]    b_par_out,
  output logic                b_drv,
  output logic [LANES-1:0]    err_a_n,
  output logic [LANES-1:0]    err_b_n,
  output logic                cfg_err
);
  localparam int LW = DW + 1;
  localparam int TW = LANES * LW;

  xdir_e         dir;
  logic [TW-1:0] a_pk, b_pk, a_lq, b_lq;

  pxc_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .oe_a_n(oe_a_n), .oe_b_n(oe_b_n),
    .dir(dir), .cfg_err(cfg_err)
  );

  pxc_latch #(.W(TW)) u_lat_a (.clk(clk), .rst_n(rst_n), .le(le_a), .d(a_pk), .q(a_lq));
  pxc_latch #(.W(TW)) u_lat_b (.clk(clk), .rst_n(rst_n), .le(le_b), .d(b_pk), .q(b_lq));

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign a_pk[l*LW +: LW] = {a_par_in[l], a_dat_in[l*DW +: DW]};
    assign b_pk[l*LW +: LW] = {b_par_in[l], b_dat_in[l*DW +: DW]};

    pxc_lane #(.DW(DW)) u_lane (
      .dir(dir), .par_thru(par_thru), .odd_sel(odd_sel),
      .le_a(le_a), .le_b(le_b),
      .a_dat(a_lq[l*LW +: DW]), .a_par(a_lq[l*LW + DW]),
      .b_dat(b_lq[l*LW +: DW]), .b_par(b_lq[l*LW + DW]),
      .a_out_dat(a_dat_out[l*DW +: DW]), .a_out_par(a_par_out[l]),
      .b_out_dat(b_dat_out[l*DW +: DW]), .b_out_par(b_par_out[l]),
      .err_a_n(err_a_n[l]), .err_b_n(err_b_n[l])
    );
  end

  assign a_drv = (dir == XDIR_B2A);
  assign b_drv = (dir == XDIR_A2B);
endmodule

// File: rtl/pxc_chk.sv
module pxc_chk #(
  parameter int LANES = 2,
  parameter int DW    = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                oe_a_n,
  input logic                oe_b_n,
  input logic                le_a,
  input logic                le_b,
  input logic                par_thru,
  input logic [LANES*DW-1:0] a_dat_in,
  input logic [LANES-1:0]    a_par_in,
  input logic                a_drv,
  input logic                b_drv,
  input logic [LANES*DW-1:0] b_dat_out,
  input logic [LANES-1:0]    b_par_out,
  input logic [LANES-1:0]    err_b_n,
  input logic                cfg_err
);
  // R1
  one_drv_chk: assert property (@(posedge clk) disable iff (!rst_n) !(a_drv && b_drv));
  // R1
  a2b_drv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_b_n && oe_a_n) |-> (b_drv && !a_drv));
  // R2
  bad_nodrv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_a_n && !oe_b_n) |-> (!a_drv && !b_drv));
  // R2
  bad_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_a_n && !oe_b_n) |=> cfg_err);
  // R2
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);
  // R3
  open_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_b_n && oe_a_n && le_a) |-> (b_dat_out == a_dat_in));
  // R4
  closed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_b_n && oe_a_n && !le_a && $past(!le_a) && $past(rst_n)) |-> $stable(b_dat_out));
  // R6
  thru_par_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_b_n && oe_a_n && par_thru && le_a) |-> (b_par_out == a_par_in));
  // R8
  rx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_b_n && oe_a_n && !(le_a && le_b)) |-> (err_b_n == '1));
endmodule

bind parity_xcvr pxc_chk #(.LANES(LANES), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .oe_a_n(oe_a_n), .oe_b_n(oe_b_n),
  .le_a(le_a), .le_b(le_b), .par_thru(par_thru),
  .a_dat_in(a_dat_in), .a_par_in(a_par_in),
  .a_drv(a_drv), .b_drv(b_drv), .b_dat_out(b_dat_out), .b_par_out(b_par_out),
  .err_b_n(err_b_n), .cfg_err(cfg_err)
);

// File: tb/tb_parity_xcvr.sv
module tb_parity_xcvr;
  localparam int CLK_PERIOD = 10;
  localparam int L = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic oe_a_n = 1'b1, oe_b_n = 1'b1, le_a = 1'b0, le_b = 1'b0;
  logic par_thru = 1'b0, odd_sel = 1'b0;
  logic [15:0] a_tb = '0, b_tb = '0, a_flip = '0, b_flip = '0;
  logic [1:0]  ap_tb = '0, bp_tb = '0, ap_flip = '0, bp_flip = '0;

  logic [15:0] a_dat_in, b_dat_in, a_dat_out, b_dat_out;
  logic [1:0]  a_par_in, b_par_in, a_par_out, b_par_out, err_a_n, err_b_n;
  logic        a_drv, b_drv, cfg_err;

  // pads: a driven bus loops back, with optional injected faults
  assign a_dat_in = a_drv ? (a_dat_out ^ a_flip) : a_tb;
  assign a_par_in = a_drv ? (a_par_out ^ ap_flip) : ap_tb;
  assign b_dat_in = b_drv ? (b_dat_out ^ b_flip) : b_tb;
  assign b_par_in = b_drv ? (b_par_out ^ bp_flip) : bp_tb;

  parity_xcvr #(.LANES(L), .DW(8)) dut (
    .clk(clk), .rst_n(rst_n), .oe_a_n(oe_a_n), .oe_b_n(oe_b_n),
    .le_a(le_a), .le_b(le_b), .par_thru(par_thru), .odd_sel(odd_sel),
    .a_dat_in(a_dat_in), .a_par_in(a_par_in), .b_dat_in(b_dat_in), .b_par_in(b_par_in),
    .a_dat_out(a_dat_out), .a_par_out(a_par_out), .a_drv(a_drv),
    .b_dat_out(b_dat_out), .b_par_out(b_par_out), .b_drv(b_drv),
    .err_a_n(err_a_n), .err_b_n(err_b_n), .cfg_err(cfg_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  // reference state
  logic [8:0] ha [L];
  logic [8:0] hb [L];
  logic       m_cfg;
  // reference outputs and pad values
  logic [8:0] m_apin [L];
  logic [8:0] m_bpin [L];
  logic [8:0] m_aout [L];
  logic [8:0] m_bout [L];
  logic [1:0] m_erra, m_errb;
  logic       m_adrv, m_bdrv;
  int         m_dir; // 0 idle, 1 A to B, 2 B to A, 3 illegal

  initial begin
    for (int l = 0; l < L; l++) begin ha[l] = '0; hb[l] = '0; end
    m_cfg = 1'b0;
  end

  function automatic logic odd_ones(input logic [8:0] v);
    return ($countones(v) % 2) == 1;
  endfunction

  function automatic logic [8:0] drive_of(input logic [8:0] src);
    logic [8:0] r;
    r[7:0] = src[7:0];
    if (par_thru) r[8] = src[8];
    else          r[8] = (($countones(src[7:0]) % 2) == 1) ^ odd_sel;
    return r;
  endfunction

  task automatic model_eval();
    logic [8:0] aq, bq;
    if (oe_a_n && oe_b_n) m_dir = 0;
    else if (oe_a_n)      m_dir = 1;
    else if (oe_b_n)      m_dir = 2;
    else                  m_dir = 3;
    m_adrv = (m_dir == 2);
    m_bdrv = (m_dir == 1);
    for (int l = 0; l < L; l++) begin
      if (m_dir == 1) begin
        m_apin[l] = {ap_tb[l], a_tb[l*8 +: 8]};
        aq = le_a ? m_apin[l] : ha[l];
        m_bout[l] = drive_of(aq);
        m_bpin[l] = m_bout[l] ^ {bp_flip[l], b_flip[l*8 +: 8]};
        bq = le_b ? m_bpin[l] : hb[l];
        m_aout[l] = drive_of(bq);
      end else if (m_dir == 2) begin
        m_bpin[l] = {bp_tb[l], b_tb[l*8 +: 8]};
        bq = le_b ? m_bpin[l] : hb[l];
        m_aout[l] = drive_of(bq);
        m_apin[l] = m_aout[l] ^ {ap_flip[l], a_flip[l*8 +: 8]};
        aq = le_a ? m_apin[l] : ha[l];
        m_bout[l] = drive_of(aq);
      end else begin
        m_apin[l] = {ap_tb[l], a_tb[l*8 +: 8]};
        m_bpin[l] = {bp_tb[l], b_tb[l*8 +: 8]};
        aq = le_a ? m_apin[l] : ha[l];
        bq = le_b ? m_bpin[l] : hb[l];
        m_aout[l] = drive_of(bq);
        m_bout[l] = drive_of(aq);
      end
      m_erra[l] = !((odd_ones(aq) != odd_sel) && (m_dir != 2 || (le_a && le_b)));
      m_errb[l] = !((odd_ones(bq) != odd_sel) && (m_dir != 1 || (le_a && le_b)));
    end
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    string dtag, ptag, atag, btag;
    dtag = "R3";
    ptag = par_thru ? "R6" : "R5";
    atag = (m_dir == 2) ? "R8" : ((m_dir == 1) ? "R7" : "R9");
    btag = (m_dir == 1) ? "R8" : ((m_dir == 2) ? "R7" : "R9");
    chk(a_drv === m_adrv && b_drv === m_bdrv, (m_dir == 3) ? "R2" : "R1",
        {30'd0, a_drv, b_drv}, {30'd0, m_adrv, m_bdrv});
    for (int l = 0; l < L; l++) begin
      if (m_dir == 1) begin
        dtag = le_a ? "R3" : "R4";
        chk(b_dat_out[l*8 +: 8] === m_bout[l][7:0], dtag, b_dat_out[l*8 +: 8], m_bout[l][7:0]);
        chk(b_par_out[l] === m_bout[l][8], ptag, b_par_out[l], m_bout[l][8]);
      end
      if (m_dir == 2) begin
        dtag = le_b ? "R3" : "R4";
        chk(a_dat_out[l*8 +: 8] === m_aout[l][7:0], dtag, a_dat_out[l*8 +: 8], m_aout[l][7:0]);
        chk(a_par_out[l] === m_aout[l][8], ptag, a_par_out[l], m_aout[l][8]);
      end
      chk(err_a_n[l] === m_erra[l], atag, err_a_n[l], m_erra[l]);
      chk(err_b_n[l] === m_errb[l], btag, err_b_n[l], m_errb[l]);
    end
    chk(cfg_err === m_cfg, "R2", cfg_err, m_cfg);
  endtask

  // inputs were applied just after a rising edge; compare at the falling edge,
  // then advance the reference at the next rising edge
  task automatic step();
    model_eval();
    @(negedge clk);
    compare();
    @(posedge clk);
    if (!rst_n) begin
      for (int l = 0; l < L; l++) begin ha[l] = '0; hb[l] = '0; end
      m_cfg = 1'b0;
    end else begin
      for (int l = 0; l < L; l++) begin
        if (le_a) ha[l] = m_apin[l];
        if (le_b) hb[l] = m_bpin[l];
      end
      if (m_dir == 3) m_cfg = 1'b1;
    end
    #1;
  endtask

  // data with correct parity under the current rule
  task automatic good_data();
    a_tb = 16'($urandom);
    b_tb = 16'($urandom);
    for (int l = 0; l < L; l++) begin
      ap_tb[l] = (^a_tb[l*8 +: 8]) ^ odd_sel;
      bp_tb[l] = (^b_tb[l*8 +: 8]) ^ odd_sel;
    end
    a_flip = '0; b_flip = '0; ap_flip = '0; bp_flip = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    @(posedge clk); #1;
    step(); step();
    rst_n = 1'b1;
    // R11: after reset the closed A latch holds zero on the B outputs
    oe_a_n = 1'b1; oe_b_n = 1'b0; le_a = 1'b0; le_b = 1'b0;
    a_tb = 16'hffff;
    model_eval();
    @(negedge clk);
    chk(b_dat_out === 16'h0000, "R11", b_dat_out, 16'h0000);
    chk(cfg_err === 1'b0, "R11", cfg_err, 1'b0);
    @(posedge clk); #1;

    // control sweep with fault injection
    for (int d = 0; d < 3; d++) begin
      for (int s = 0; s < 4; s++) begin
        for (int e = 0; e < 4; e++) begin
          oe_a_n = (d != 2); oe_b_n = (d != 1);
          par_thru = s[0]; odd_sel = s[1];
          le_a = e[0]; le_b = e[1];
          for (int v = 0; v < 5; v++) begin
            good_data();
            if (v == 1) a_tb[$urandom_range(15, 0)] ^= 1'b1;
            if (v == 2) b_tb[$urandom_range(15, 0)] ^= 1'b1;
            if (v == 3) begin a_flip[$urandom_range(15, 0)] = 1'b1; b_flip[$urandom_range(15, 0)] = 1'b1; end
            if (v == 4) begin ap_tb = ~ap_tb; bp_flip = 2'b01; ap_flip = 2'b10; end
            step();
          end
        end
      end
    end

    // R10: a fault in lane 0 only leaves lane 1 clean
    oe_a_n = 1'b1; oe_b_n = 1'b0; le_a = 1'b1; le_b = 1'b1; par_thru = 1'b0; odd_sel = 1'b0;
    good_data();
    a_tb[3] ^= 1'b1;
    model_eval();
    @(negedge clk);
    chk(err_a_n === 2'b10, "R10", err_a_n, 2'b10);
    chk(b_dat_out[15:8] === a_tb[15:8], "R10", b_dat_out[15:8], a_tb[15:8]);
    @(posedge clk); #1;

    // R4: capture then close the A latch and change the input
    good_data();
    a_tb = 16'h5aa5;
    step();
    le_a = 1'b0;
    a_tb = 16'h1234;
    model_eval();
    @(negedge clk);
    chk(b_dat_out === 16'h5aa5, "R4", b_dat_out, 16'h5aa5);
    @(posedge clk); #1;

    // R2: illegal enables, flag sticks, reset clears
    oe_a_n = 1'b0; oe_b_n = 1'b0;
    step();
    oe_a_n = 1'b1; oe_b_n = 1'b1;
    step(); step();
    rst_n = 1'b0;
    step();
    rst_n = 1'b1;
    model_eval();
    @(negedge clk);
    chk(cfg_err === 1'b0, "R2", cfg_err, 1'b0);
    @(posedge clk); #1;

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule